// File: doc/BRIEF.md
# Bit Manipulation and Barrel Shift Unit

This unit carries out the bit and shift group of a 16-bit processor's instruction set on one target register value. It supports four single-bit operations: test, change (toggle), set and clear. It also supports four multi-bit moves: shift left, shift right, rotate left and rotate right.

A 4-bit field gives the bit number or shift count. Whether that field is used depends on a static/dynamic select:

- **Static mode:** the field holds the number itself.
- **Dynamic mode:** the field names a register. The register file reads that register and presents its value on a separate count input. The unit then uses only the low four bits of that value.

All eight operations share one logarithmic rotation network. The unit produces four results:

- the new register value;
- a write-enable, which is low for bit test;
- a zero flag;
- a carry flag.

The results are captured in an output register when a start strobe is high. A done strobe follows one cycle later.

Top module: `bsu_top`

## Requirements
- R1: The operation code selects the operation: 3'b000 test, 3'b001 change, 3'b010 set, 3'b011 clear, 3'b100 shift left, 3'b101 shift right, 3'b110 rotate left, 3'b111 rotate right. Bit n means bit n of the target, with bit 0 the least significant.
- R2: With `dyn_sel`=0 the number n is `num_field`. With `dyn_sel`=1 it is `dyn_count[3:0]`, and `num_field` and `dyn_count[15:4]` have no effect.
- R3: Bit test returns the target unchanged with `wr_en` low, Z equal to the inverse of bit n, and C equal to 0.
- R4: Change, set and clear return the target with bit n toggled, forced to 1 or forced to 0 respectively. `wr_en` is high, Z is the inverse of bit n before modification, and C is 0.
- R5: Shifts by n fill the vacated bits with zero. C is the last bit shifted out (target[16-n] for left, target[n-1] for right), and Z is 1 exactly when the result is zero.
- R6: Rotates by n move bits circularly with no carry in the loop. C is the last bit that wrapped around (target[16-n] for left, target[n-1] for right), and Z is 1 exactly when the result is zero.
- R7: A shift or rotate with n=0 returns the target unchanged with C=0.
- R8: Results load on a rising clock edge where `start` is high. `done` is high for exactly the following cycle. `wr_en` is high only while `done` is high. The outputs hold their values while `start` stays low.
- R9: Synchronous active-high reset clears `result`, `wr_en`, `z_flag`, `c_flag` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for the current operation |
| target | input | 16 | Target register value |
| dyn_sel | input | 1 | 0: number from `num_field`; 1: number from `dyn_count` |
| op | input | 3 | Operation code |
| num_field | input | 4 | Immediate bit number or count |
| dyn_count | input | 16 | Value of the register named by the field |
| result | output | 16 | Registered new target value |
| wr_en | output | 1 | Write-back request, valid with `done` |
| z_flag | output | 1 | Registered zero flag |
| c_flag | output | 1 | Registered carry flag |
| done | output | 1 | One-cycle strobe marking valid outputs |

## Verification
Every result of this block (value, write-enable, Z, C and done) comes out of a single register stage. All of them are therefore due on the first rising edge after the edge that sees `start` high.

Each scenario task works as follows:
- it drives its inputs on a falling edge;
- it holds `start` through one rising edge and then drops it;
- it samples all outputs at the next falling edge, where `done` must be high.

A hold check follows with `start` low for two cycles. It confirms that `done` falls and that the value does not move. The bench computes expected values with a bit-by-bit loop model that does not share the rotation network's structure.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    parameter int unsigned DW = 16;
    localparam int unsigned CW = $clog2(DW);

    typedef enum logic [2:0] {
        OP_BTST = 3'b000,
        OP_BFLIP = 3'b001,
        OP_BSET = 3'b010,
        OP_BCLR = 3'b011,
        OP_SHL  = 3'b100,
        OP_SHR  = 3'b101,
        OP_ROL  = 3'b110,
        OP_ROR  = 3'b111
    } bsu_op_e;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          wr;
        logic          z;
        logic          c;
    } bsu_res_t;

    function automatic logic is_move_op(bsu_op_e o);
        return o[2];
    endfunction

    function automatic logic is_rotate_op(bsu_op_e o);
        return o[2] & o[1];
    endfunction

    function automatic logic moves_left(bsu_op_e o);
        return ~o[0];
    endfunction
endpackage

// File: rtl/bsu_amount_sel.sv
module bsu_amount_sel #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic          dyn_sel,
    input  logic [CW-1:0] field,
    input  logic [W-1:0]  dyn_val,
    output logic [CW-1:0] amt
);
    always_comb begin
        amt = dyn_sel ? dyn_val[CW-1:0] : field;
    end
endmodule

// File: rtl/bsu_rotator.sv
module bsu_rotator #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    input  logic          go_left,
    output logic [W-1:0]  dout
);
    logic [CW-1:0] left_amt;
    logic [W-1:0]  stage [CW+1];

    // a right rotate by n equals a left rotate by (W - n) mod W
    always_comb begin
        left_amt = go_left ? amt : (CW'(0) - amt);
    end

    assign stage[0] = din;

    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        always_comb begin
            if (left_amt[s])
                stage[s+1] = {stage[s][W-SH-1:0], stage[s][W-1:W-SH]};
            else
                stage[s+1] = stage[s];
        end
    end

    assign dout = stage[CW];
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    input  logic [1:0]    kind,
    output logic [W-1:0]  dout,
    output logic          sel_bit
);
    logic [W-1:0] onehot;

    always_comb begin
        onehot  = W'(1) << amt;
        sel_bit = |(din & onehot);
        unique case (kind)
            2'b00:   dout = din;
            2'b01:   dout = din ^ onehot;
            2'b10:   dout = din | onehot;
            default: dout = din & ~onehot;
        endcase
    end
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [15:0]   target,
    input  logic          dyn_sel,
    input  logic [2:0]    op,
    input  logic [3:0]    num_field,
    input  logic [15:0]   dyn_count,
    output logic [15:0]   result,
    output logic          wr_en,
    output logic          z_flag,
    output logic          c_flag,
    output logic          done
);
    bsu_op_e       op_e;
    logic [CW-1:0] amt;
    logic [DW-1:0] rot_val;
    logic [DW-1:0] bit_val;
    logic          bit_sel;
    logic [DW-1:0] keep_mask;
    bsu_res_t      nxt;
    bsu_res_t      cur;

    assign op_e = bsu_op_e'(op);

    bsu_amount_sel #(.W(DW), .CW(CW)) u_amt (
        .dyn_sel (dyn_sel),
        .field   (num_field),
        .dyn_val (dyn_count),
        .amt     (amt)
    );

    bsu_rotator #(.W(DW), .CW(CW)) u_rot (
        .din     (target),
        .amt     (amt),
        .go_left (moves_left(op_e)),
        .dout    (rot_val)
    );

    bsu_bitop #(.W(DW), .CW(CW)) u_bit (
        .din     (target),
        .amt     (amt),
        .kind    (op[1:0]),
        .dout    (bit_val),
        .sel_bit (bit_sel)
    );

    always_comb begin
        // shifts keep only the bits that did not wrap
        if (is_rotate_op(op_e))
            keep_mask = '1;
        else if (moves_left(op_e))
            keep_mask = {DW{1'b1}} << amt;
        else
            keep_mask = {DW{1'b1}} >> amt;

        nxt = '0;
        if (is_move_op(op_e)) begin
            nxt.value = rot_val & keep_mask;
            nxt.wr    = 1'b1;
            nxt.z     = ~|nxt.value;
            // last bit out lands at the low end going left, high end going right
            nxt.c     = (amt != '0) &&
                        (moves_left(op_e) ? rot_val[0] : rot_val[DW-1]);
        end else begin
            nxt.value = bit_val;
            nxt.wr    = (op_e != OP_BTST);
            nxt.z     = ~bit_sel;
            nxt.c     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            done <= 1'b0;
        end else begin
            done <= start;
            if (start) cur <= nxt;
        end
    end

    assign result = cur.value;
    assign wr_en  = cur.wr & done;
    assign z_flag = cur.z;
    assign c_flag = cur.c;

    // R8
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    // R8
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && $stable(result));
    // R3
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        start && op == 3'b000 |=> !wr_en && result == $past(target));
    // R6
    rotate_popcount_chk: assert property (@(posedge clk) disable iff (rst)
        start && op[2:1] == 2'b11 |=> $countones(result) == $countones($past(target)));
    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        start && op[2] && amt == '0 |=> result == $past(target) && !c_flag);
endmodule

// File: tb/bsu_top_tb.sv
module bsu_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] target;
    logic        dyn_sel;
    logic [2:0]  op;
    logic [3:0]  num_field;
    logic [15:0] dyn_count;
    logic [15:0] result;
    logic        wr_en, z_flag, c_flag, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    bsu_top u_dut (
        .clk(clk), .rst(rst), .start(start), .target(target),
        .dyn_sel(dyn_sel), .op(op), .num_field(num_field), .dyn_count(dyn_count),
        .result(result), .wr_en(wr_en), .z_flag(z_flag), .c_flag(c_flag), .done(done)
    );

    // independent bit-by-bit reference: {value, wr, z, c}
    function automatic logic [18:0] model(input logic [2:0] o, input logic [15:0] t, input int n);
        logic [15:0] v = t;
        logic wr = 1'b1, z, c = 1'b0;
        logic b;
        if (!o[2]) begin
            b = t[n];
            z = ~b;
            case (o[1:0])
                2'b00: wr = 1'b0;
                2'b01: v[n] = ~b;
                2'b10: v[n] = 1'b1;
                default: v[n] = 1'b0;
            endcase
        end else begin
            for (int i = 0; i < n; i++) begin
                if (!o[0]) begin
                    c = v[15];
                    v = {v[14:0], o[1] ? v[15] : 1'b0};
                end else begin
                    c = v[0];
                    v = {o[1] ? v[0] : 1'b0, v[15:1]};
                end
            end
            z = (v == 16'h0);
        end
        return {v, wr, z, c};
    endfunction

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got {res,wr,z,c}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] o, input logic [15:0] t,
                          input logic ds, input logic [3:0] fld, input logic [15:0] dc);
        int n;
        @(negedge clk);
        op = o; target = t; dyn_sel = ds; num_field = fld; dyn_count = dc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = ds ? int'(dc[3:0]) : int'(fld);
        check(req, {result, wr_en, z_flag, c_flag}, model(o, t, n));
        n_tests++;
        if (done !== 1'b1) begin
            n_fail++;
            $display("FAIL R8: done=%b expected 1", done);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b1; op = 3'b110; target = 16'hFFFF; num_field = 4'd3;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R9", {result, wr_en, z_flag, c_flag}, 19'h0);
        n_tests++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R9: done=%b expected 0", done); end
    endtask

    task automatic test_bit_ops();
        run_op("R3", 3'b000, 16'h0020, 1'b0, 4'd5, 16'h0);
        run_op("R3", 3'b000, 16'hFFDF, 1'b0, 4'd5, 16'h0);
        run_op("R4", 3'b001, 16'h8001, 1'b0, 4'd15, 16'h0);
        run_op("R4", 3'b010, 16'h0000, 1'b0, 4'd0, 16'h0);
        run_op("R4", 3'b011, 16'hFFFF, 1'b0, 4'd7, 16'h0);
        run_op("R1", 3'b001, 16'h1234, 1'b0, 4'd2, 16'h0);
    endtask

    task automatic test_shifts();
        run_op("R5", 3'b100, 16'hC003, 1'b0, 4'd1, 16'h0);
        run_op("R5", 3'b100, 16'h0001, 1'b0, 4'd15, 16'h0);
        run_op("R5", 3'b101, 16'h8001, 1'b0, 4'd1, 16'h0);
        run_op("R5", 3'b101, 16'h8000, 1'b0, 4'd15, 16'h0);
        run_op("R5", 3'b101, 16'hA5A5, 1'b0, 4'd4, 16'h0);
    endtask

    task automatic test_rotates();
        run_op("R6", 3'b110, 16'h8001, 1'b0, 4'd1, 16'h0);
        run_op("R6", 3'b110, 16'h1234, 1'b0, 4'd12, 16'h0);
        run_op("R6", 3'b111, 16'h0001, 1'b0, 4'd1, 16'h0);
        run_op("R6", 3'b111, 16'hA5C3, 1'b0, 4'd7, 16'h0);
    endtask

    task automatic test_zero_count();
        run_op("R7", 3'b100, 16'hBEEF, 1'b0, 4'd0, 16'h0);
        run_op("R7", 3'b111, 16'hBEEF, 1'b0, 4'd0, 16'h0);
        run_op("R7", 3'b101, 16'h0000, 1'b0, 4'd0, 16'h0);
    endtask

    task automatic test_dynamic();
        // field disagrees with the register; upper count bits set
        run_op("R2", 3'b100, 16'h00FF, 1'b1, 4'd9, 16'hFFF3);
        run_op("R2", 3'b010, 16'h0000, 1'b1, 4'd0, 16'h1230);
        run_op("R2", 3'b110, 16'h4321, 1'b1, 4'd1, 16'h0010);
        run_op("R2", 3'b000, 16'h0800, 1'b1, 4'd2, 16'hABCB);
    endtask

    task automatic test_hold();
        logic [15:0] last;
        run_op("R8", 3'b010, 16'h0F00, 1'b0, 4'd1, 16'h0);
        last = result;
        @(negedge clk);
        target = 16'h5555; op = 3'b100; num_field = 4'd3;
        n_tests++;
        if (done !== 1'b0 || wr_en !== 1'b0) begin
            n_fail++; $display("FAIL R8: done=%b wr_en=%b expected 0 0", done, wr_en);
        end
        @(negedge clk);
        n_tests++;
        if (result !== last) begin
            n_fail++; $display("FAIL R8: result=%h expected %h", result, last);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; target = '0; dyn_sel = 1'b0; op = '0;
        num_field = '0; dyn_count = '0;
        test_reset();
        test_bit_ops();
        test_shifts();
        test_rotates();
        test_zero_count();
        test_dynamic();
        test_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule